// File: doc/BRIEF.md
# Nibble-Wide CRC5 Engine

This block keeps a running 5-bit cyclic redundancy check over a message that arrives four bits at a time. The generator is x^5 + x^2 + 1. A single clock edge performs the work of four single-bit steps of the usual shift-register form. In that form there is no zero padding, and each step feeds back the incoming bit XORed with the top register bit. Each next-state bit is an XOR of chosen data and state bits. There are no AND or OR terms.

Before a message starts, software-free control logic asserts the load strobe to return the register to its seed. The seed is a parameter and defaults to all ones. Each nibble with its strobe high then advances the register. Once the last nibble of the message is absorbed, the register holds the check value. Inversion, bit reversal and framing are handled outside the block.

Top module: `crc5_nibble`

## Requirements
- R1: While `rst` is high at a rising clock edge, `crc` takes the `SEED` parameter value (default 5'b11111) after that edge.
- R2: With `rst` low, `init` high at an edge loads `SEED` into `crc`. This happens whether `din_vld` is high or low, so `init` overrides a valid nibble.
- R3: With `rst`, `init` and `din_vld` all low, `crc` keeps its value and `din` has no effect.
- R4: With `din_vld` high and `init` low, `crc` becomes the state reached by four single-bit steps, starting from the old `crc`. `din[3]` is consumed first and `din[0]` last. One step with bit b and state c sets fb = b ^ c[4], then next = {c[3], c[2], c[1]^fb, c[0], fb}, written from bit 4 down to bit 0.
- R5: From state 5'b00000, nibble 4'b1000 yields 5'b01101. From the default seed, nibbles 0000, 1000, 0000 in turn yield 00110, 00010 and 00101.
- R6: From state 5'b10000, nibble 4'b0000 yields 5'b01101, the same value as R5. Nibble 4'b1000 from that state yields 5'b00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, loads the seed |
| init | input | 1 | Load seed before a new message |
| din | input | 4 | Message nibble, bit 3 sent first |
| din_vld | input | 1 | Nibble on `din` is consumed this cycle |
| crc | output | 5 | Running check register |

## Verification
A seed load and a nibble update can be requested in the same cycle. The bench provokes this by raising `init` together with `din_vld` and a random nibble in the middle of a random stream. It then judges the result by expecting the seed one edge later, with no trace of the nibble. Every other update is compared against a bench-side one-bit-at-a-time model run four steps from random seeds. Extra instances with seeds 00000 and 10000 confirm that a data bit and a state bit in the same position produce matching results.

// File: rtl/crc5_nibble.sv
module crc5_nibble #(
  parameter int CW = 5,
  parameter int DW = 4,
  parameter logic [CW-1:0] POLY = 5'b00101,
  parameter logic [CW-1:0] SEED = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic [DW-1:0] din,
  input  logic          din_vld,
  output logic [CW-1:0] crc
);

  function automatic logic [CW-1:0] advance(input logic [CW-1:0] s,
                                            input logic [DW-1:0] d);
    logic fb;
    for (int i = DW - 1; i >= 0; i--) begin
      fb = d[i] ^ s[CW-1];
      s  = {s[CW-2:0], 1'b0} ^ ({CW{fb}} & POLY);
    end
    return s;
  endfunction

  logic [CW-1:0] nxt;
  assign nxt = advance(crc, din);

  always_ff @(posedge clk) begin
    if (rst || init) crc <= SEED;
    else if (din_vld) crc <= nxt;
  end

endmodule

module crc5_nibble_chk #(
  parameter logic [4:0] SEED = 5'b11111
) (
  input logic       clk,
  input logic       rst,
  input logic       init,
  input logic [3:0] din,
  input logic       din_vld,
  input logic [4:0] crc
);

  function automatic logic [4:0] bitstep(input logic [4:0] c, input logic b);
    logic f;
    f = b ^ c[4];
    return {c[3], c[2], c[1] ^ f, c[0], f};
  endfunction

  function automatic logic [4:0] four(input logic [4:0] c, input logic [3:0] d);
    return bitstep(bitstep(bitstep(bitstep(c, d[3]), d[2]), d[1]), d[0]);
  endfunction

  p_reset_seed_r1: assert property (@(posedge clk) rst |=> crc == SEED);

  p_init_wins_r2: assert property (@(posedge clk) disable iff (rst)
    init |=> crc == SEED);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!init && !din_vld) |=> $stable(crc));

  p_four_steps_r4: assert property (@(posedge clk) disable iff (rst)
    (din_vld && !init) |=> crc == four($past(crc), $past(din)));

  p_zero_state_r5: assert property (@(posedge clk) disable iff (rst)
    (din_vld && !init && crc == 5'b00000 && din == 4'b1000) |=> crc == 5'b01101);

  p_top_state_r6: assert property (@(posedge clk) disable iff (rst)
    (din_vld && !init && crc == 5'b10000 && din == 4'b0000) |=> crc == 5'b01101);

endmodule

bind crc5_nibble crc5_nibble_chk #(.SEED(SEED)) u_chk (
  .clk(clk), .rst(rst), .init(init), .din(din), .din_vld(din_vld), .crc(crc)
);

// File: tb/test_crc5_nibble.sv
module test_crc5_nibble;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       init = 1'b0;
  logic [3:0] din = '0;
  logic       din_vld = 1'b0;
  logic [4:0] crc, crc_z, crc_t;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  crc5_nibble i_crc5_nibble (.clk(clk), .rst(rst), .init(init), .din(din),
                             .din_vld(din_vld), .crc(crc));
  crc5_nibble #(.SEED(5'b00000)) i_zero (.clk(clk), .rst(rst), .init(init),
                             .din(din), .din_vld(din_vld), .crc(crc_z));
  crc5_nibble #(.SEED(5'b10000)) i_top (.clk(clk), .rst(rst), .init(init),
                             .din(din), .din_vld(din_vld), .crc(crc_t));

  localparam int NV = 3;
  localparam logic [8:0] VEC [NV] = '{
    {4'b0000, 5'b00110},
    {4'b1000, 5'b00010},
    {4'b0000, 5'b00101}
  };

  function automatic logic [4:0] ref_bit(input logic [4:0] c, input logic b);
    logic f;
    f = b ^ c[4];
    return {c[3], c[2], c[1] ^ f, c[0], f};
  endfunction

  function automatic logic [4:0] ref_nib(input logic [4:0] c, input logic [3:0] d);
    for (int k = 3; k >= 0; k--) c = ref_bit(c, d[k]);
    return c;
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: crc=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic i, input logic v, input logic [3:0] d);
    @(negedge clk);
    rst = r; init = i; din_vld = v; din = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [4:0] model;
    logic [3:0] nib;
    logic v;
    drive(1, 0, 0, 4'h0);
    check("R1", crc, 5'b11111);
    check("R1", crc_z, 5'b00000);
    check("R1", crc_t, 5'b10000);
    // R1 reset wins over a valid nibble
    drive(1, 0, 1, 4'hA);
    check("R1", crc, 5'b11111);

    for (int n = 0; n < NV; n++) begin
      drive(0, 0, 1, VEC[n][8:5]);
      check("R5", crc, VEC[n][4:0]);
    end

    drive(1, 0, 0, 4'h0);
    drive(0, 0, 1, 4'b1000);
    check("R5", crc_z, 5'b01101);
    check("R6", crc_t, 5'b00000);
    drive(1, 0, 0, 4'h0);
    drive(0, 0, 1, 4'b0000);
    check("R6", crc_t, 5'b01101);
    check("R6", crc_z, 5'b00000);

    // R3 idle cycles with changing data hold the register
    model = crc;
    drive(0, 0, 0, 4'hF);
    check("R3", crc, model);
    drive(0, 0, 0, 4'h5);
    check("R3", crc, model);

    // R2 init with valid nibble loads seed
    drive(0, 1, 1, 4'h9);
    check("R2", crc, 5'b11111);
    check("R2", crc_t, 5'b10000);
    drive(0, 1, 0, 4'h3);
    check("R2", crc, 5'b11111);

    // R4 random streams, random start states
    for (int s = 0; s < 40; s++) begin
      drive(1, 0, 0, 4'h0);
      model = 5'b11111;
      for (int w = 0; w < ($urandom % 4); w++) begin
        nib = 4'($urandom);
        drive(0, 0, 1, nib);
        model = ref_nib(model, nib);
      end
      for (int k = 0; k < 60; k++) begin
        nib = 4'($urandom);
        v = ($urandom % 4) != 0;
        if (k == 30) begin
          drive(0, 1, 1, nib);
          model = 5'b11111;
          check("R2", crc, model);
        end else begin
          drive(0, 0, v, nib);
          if (v) model = ref_nib(model, nib);
          check(v ? "R4" : "R3", crc, model);
        end
      end
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: crc=%b expected=completion", crc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule